// File: doc/BRIEF.md
# PRNG Phase Sequencer

This block is the control unit of a small stream-style pseudorandom generator. The generator's datapath works in three phases. First the key and IV are shifted in. Then a fixed number of mixing rounds runs. After that the datapath runs freely and produces output bits.

The sequencer drives three one-hot phase strobes and a clock enable for the third shift register of the datapath. It also drives an output-valid strobe that marks one usable output bit every five cycles. The first two shift registers run on every cycle and take no control from this block.

A single 6-bit phase timer measures the phase lengths. A parameter selects how it counts: either as a plain binary counter, or as a maximal-length LFSR that needs less feedback logic. The timer is never reloaded between phases. Each phase exit is therefore decoded from the timer code reached after a fixed number of steps since reset. The timer value is brought out so that the counting sequence can be observed.

Top module: `prng_phase_seq`

## Requirements
- R1: While `rst` is sampled high, the block shows the loading phase with `valid_o`=0 at the next clock edge. The timer then reads 6'b111111 in the LFSR option and 6'd0 in the binary option.
- R2: The strobe vector {`load_o`,`init_o`,`run_o`} always holds exactly one of three codes: 3'b100 for loading, 3'b010 for initialization, 3'b001 for running.
- R3: After reset is released, loading lasts exactly 18 cycles, counting the cycle that shows the reset state.
- R4: Initialization follows loading and lasts exactly 36 cycles. Running follows it and continues until reset.
- R5: In the LFSR option the timer steps as next = {t[1]^t[0], t[5:1]} (polynomial x^6+x+1), starting from 6'b111111. It passes through all 63 nonzero codes before it returns to the seed.
- R6: In the binary option the timer adds one each cycle, starting from 0, and wraps from 63 to 0.
- R7: The timer advances on every cycle after reset in every phase, and no phase change reloads it. The loading and initialization exits are the codes reached 17 and 53 steps after reset.
- R8: In running, `valid_o` is high for exactly one cycle in every five. The first pulse falls on the fifth cycle of running, and each later pulse comes five cycles after the one before it.
- R9: `ce3_o` is high throughout loading and initialization. In running it is high only in the cycles where `valid_o` is high.
- R10: A reset applied during running brings the block back to the R1 state. The full phase sequence then repeats with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_o | output | 1 | Loading phase strobe |
| init_o | output | 1 | Initialization phase strobe |
| run_o | output | 1 | Running phase strobe |
| ce3_o | output | 1 | Clock enable for the third shift register |
| valid_o | output | 1 | Output bit valid, one cycle in five during running |
| timer_o | output | 6 | Current phase timer code |

## Verification
The assertions check four properties on every cycle. The strobes must stay one-hot, and phases may only move forward. In the LFSR option each timer value must follow from the one before it by the feedback rule. Each valid pulse must close a gap of exactly five running cycles, and the third-register enable must follow the phase and the valid pulse. Some behaviour needs whole scenarios to show: the exact 18- and 36-cycle phase lengths in both timer options, the full 63-code tour of the LFSR, and a clean restart after a reset in mid-run. The bench's cycle-by-cycle scoreboard covers these.

// File: rtl/prng_phase_seq.sv
module prng_phase_seq #(
  parameter bit          TIMER_LFSR  = 1'b1,
  parameter int unsigned LOAD_CYCLES = 18,
  parameter int unsigned INIT_CYCLES = 36,
  parameter int unsigned OUT_PERIOD  = 5
) (
  input  logic       clk,
  input  logic       rst,
  output logic       load_o,
  output logic       init_o,
  output logic       run_o,
  output logic       ce3_o,
  output logic       valid_o,
  output logic [5:0] timer_o
);

  localparam int unsigned TW = 6;
  localparam int unsigned PW = (OUT_PERIOD > 1) ? $clog2(OUT_PERIOD) : 1;
  localparam logic [TW-1:0] SEED = TIMER_LFSR ? {TW{1'b1}} : '0;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] t);
    if (TIMER_LFSR) return {t[1] ^ t[0], t[TW-1:1]};
    else            return t + 1'b1;
  endfunction

  function automatic logic [TW-1:0] code_at(input int unsigned n);
    logic [TW-1:0] t;
    t = SEED;
    for (int unsigned i = 0; i < n; i++) t = step(t);
    return t;
  endfunction

  localparam logic [TW-1:0] LOAD_EXIT = code_at(LOAD_CYCLES - 1);
  localparam logic [TW-1:0] INIT_EXIT = code_at(LOAD_CYCLES + INIT_CYCLES - 1);

  typedef enum logic [2:0] {
    PH_LOAD = 3'b100,
    PH_INIT = 3'b010,
    PH_RUN  = 3'b001
  } phase_t;

  phase_t        phase_q;
  logic [TW-1:0] timer_q;
  logic [PW-1:0] div_q;
  logic          tick;

  always_ff @(posedge clk) begin
    if (rst) timer_q <= SEED;
    else     timer_q <= step(timer_q);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_LOAD;
    else begin
      unique case (phase_q)
        PH_LOAD: if (timer_q == LOAD_EXIT) phase_q <= PH_INIT;
        PH_INIT: if (timer_q == INIT_EXIT) phase_q <= PH_RUN;
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign tick = (phase_q == PH_RUN) && (div_q == PW'(OUT_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || phase_q != PH_RUN) div_q <= '0;
    else if (tick)                div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end

  assign {load_o, init_o, run_o} = phase_q;
  assign valid_o = tick;
  assign ce3_o   = load_o | init_o | tick;
  assign timer_o = timer_q;

endmodule

// File: rtl/prng_phase_seq_chk.sv
module prng_phase_seq_chk #(
  parameter bit TIMER_LFSR = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       load_o,
  input logic       init_o,
  input logic       run_o,
  input logic       ce3_o,
  input logic       valid_o,
  input logic [5:0] timer_o
);

  logic       live_q;
  logic [2:0] gap_q;

  always_ff @(posedge clk) begin
    live_q <= !rst;
    if (rst || !run_o || valid_o) gap_q <= '0;
    else if (gap_q != 3'd7)       gap_q <= gap_q + 1'b1;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot({load_o, init_o, run_o}));

  a_r4_run_holds: assert property (@(posedge clk) disable iff (rst)
    run_o |=> run_o);

  a_r3_load_next: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (load_o || init_o));

  a_r4_init_next: assert property (@(posedge clk) disable iff (rst)
    init_o |=> (init_o || run_o));

  a_r8_valid_gap: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (run_o && gap_q == 3'd4));

  a_r8_valid_due: assert property (@(posedge clk) disable iff (rst)
    (run_o && gap_q == 3'd4) |-> valid_o);

  a_r9_ce3_quiet: assert property (@(posedge clk) disable iff (rst)
    (run_o && !valid_o) |-> !ce3_o);

  a_r9_ce3_setup: assert property (@(posedge clk) disable iff (rst)
    (load_o || init_o) |-> ce3_o);

  generate
    if (TIMER_LFSR) begin : g_lfsr
      a_r5_lfsr_step: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (timer_o == {$past(timer_o[1]) ^ $past(timer_o[0]), $past(timer_o[5:1])}));
    end else begin : g_bin
      a_r6_bin_step: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (timer_o == $past(timer_o) + 6'd1));
    end
  endgenerate

endmodule

bind prng_phase_seq prng_phase_seq_chk #(.TIMER_LFSR(TIMER_LFSR)) u_chk (
  .clk(clk), .rst(rst), .load_o(load_o), .init_o(init_o), .run_o(run_o),
  .ce3_o(ce3_o), .valid_o(valid_o), .timer_o(timer_o)
);

// File: tb/test_prng_phase_seq.sv
`timescale 1ns/1ps
module test_prng_phase_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       l_load, l_init, l_run, l_ce3, l_valid;
  logic [5:0] l_timer;
  logic       b_load, b_init, b_run, b_ce3, b_valid;
  logic [5:0] b_timer;

  prng_phase_seq #(.TIMER_LFSR(1'b1)) i_prng_phase_seq (
    .clk(clk), .rst(rst), .load_o(l_load), .init_o(l_init), .run_o(l_run),
    .ce3_o(l_ce3), .valid_o(l_valid), .timer_o(l_timer));

  prng_phase_seq #(.TIMER_LFSR(1'b0)) i_prng_phase_seq_bin (
    .clk(clk), .rst(rst), .load_o(b_load), .init_o(b_init), .run_o(b_run),
    .ce3_o(b_ce3), .valid_o(b_valid), .timer_o(b_timer));

  typedef struct packed {
    logic [7:0] idx;
    logic [4:0] flags;
    logic [5:0] tl;
    logic [5:0] tb;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         fails  = 0;
  logic [5:0] hist [0:63];
  bit         record = 1'b0;

  task automatic check(input bit ok, input string what, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", what, got, expv);
    end
  endtask

  function automatic logic [5:0] lstep(input logic [5:0] t);
    return {t[1] ^ t[0], t[5:1]};
  endfunction

  task automatic push(input int k, input logic [5:0] lf);
    exp_t e;
    bit ld, it, rn, vl;
    ld = (k < 18);
    it = (k >= 18) && (k < 54);
    rn = (k >= 54);
    vl = rn && ((k - 54) % 5 == 4);
    e.idx   = 8'(k);
    e.flags = {ld, it, rn, ld | it | vl, vl};
    e.tl    = lf;
    e.tb    = 6'(k);
    sb.push_back(e);
  endtask

  task automatic check_reset(input string tag);
    check({l_load, l_init, l_run, l_valid} == 4'b1000, {tag, " lfsr strobes at reset"},
          {l_load, l_init, l_run, l_valid}, 4'b1000);
    check({b_load, b_init, b_run, b_valid} == 4'b1000, {tag, " bin strobes at reset"},
          {b_load, b_init, b_run, b_valid}, 4'b1000);
    check(l_timer == 6'h3f, {tag, " lfsr seed"}, l_timer, 6'h3f);
    check(b_timer == 6'h00, {tag, " bin seed"}, b_timer, 0);
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      check({l_load, l_init, l_run, l_ce3, l_valid} == e.flags,
            $sformatf("R2 R3 R4 R8 R9 lfsr option idx=%0d", e.idx),
            {l_load, l_init, l_run, l_ce3, l_valid}, e.flags);
      check({b_load, b_init, b_run, b_ce3, b_valid} == e.flags,
            $sformatf("R2 R3 R4 R8 R9 bin option idx=%0d", e.idx),
            {b_load, b_init, b_run, b_ce3, b_valid}, e.flags);
      check(l_timer == e.tl, $sformatf("R5 R7 lfsr timer idx=%0d", e.idx), l_timer, e.tl);
      check(b_timer == e.tb, $sformatf("R6 R7 bin timer idx=%0d", e.idx), b_timer, e.tb);
      if (record && e.idx < 64) hist[e.idx[5:0]] = l_timer;
    end
  end

  initial begin
    #(8 * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] lf;
    logic [63:0] seen;
    int distinct;
    repeat (3) @(posedge clk);
    #1;
    check_reset("R1");
    hist[0] = l_timer;
    record = 1'b1;
    rst = 1'b0;
    lf = 6'h3f;
    for (int k = 1; k <= 130; k++) begin
      @(posedge clk); #1;
      lf = lstep(lf);
      push(k, lf);
    end
    @(negedge clk); #1;
    record = 1'b0;

    // R5: all 63 nonzero codes visited, code 63 back at the seed
    seen = '0;
    distinct = 0;
    for (int i = 0; i < 63; i++) begin
      if (!seen[hist[i]]) distinct++;
      seen[hist[i]] = 1'b1;
    end
    check(distinct == 63 && !seen[0], "R5 distinct nonzero LFSR codes", distinct, 63);
    check(hist[63] == 6'h3f, "R5 LFSR period returns to seed", hist[63], 6'h3f);

    // R10: reset during running
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check_reset("R10");
    rst = 1'b0;
    lf = 6'h3f;
    for (int k = 1; k <= 80; k++) begin
      @(posedge clk); #1;
      lf = lstep(lf);
      push(k, lf);
    end
    @(negedge clk); #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule